// File: doc/BRIEF.md
# LCD Line and Frame Sync Generator

This block produces the horizontal and vertical synchronisation pulses for a small LCD panel that takes its pixels as serial RGB bytes. Everything runs on one pixel-port clock. Each pixel takes three ticks, one for each colour byte. Two independent free-running counters drive the syncs, each in the manner of a PWM output. The horizontal counter sets the line period. The vertical counter sets the frame period, and that period is a whole number of line periods. Both syncs are active low, and the edge that marks the start of a line or frame is the falling edge.

Each sync has its own enable. The frame counter is meant to be started first, and the line counter at least one tick later. Because the frame period is an exact multiple of the line period, the gap between the two enables then fixes the phase of every frame start against the nearest line start, and that phase is the same on every run. Two one-cycle strobes mark the start of each line and the start of each frame.

The timing values are parameters. The defaults suit a 320x240 panel: 408 pixel times per line (1224 ticks), a 90-tick line pulse, 241 lines per frame (240 visible plus 1 blank) and a frame pulse three lines long.

Top module: `lcd_sync_gen`

## Requirements
- R1: During and straight after reset, `hs_n` and `vs_n` are high and `line_start` and `frame_start` are low.
- R2: While `hs_en` stays high, `line_start` pulses for one cycle every HS_PERIOD = TICKS_PER_PIX*LINE_PIXELS cycles. The first pulse comes in the first cycle after the clock edge that samples `hs_en` high.
- R3: `hs_n` goes low (active) on each `line_start` cycle and stays low for exactly HS_WIDTH cycles. It is high for the rest of the line period.
- R4: While `vs_en` stays high, `frame_start` pulses for one cycle every VS_PERIOD = FRAME_LINES*HS_PERIOD cycles. The first pulse comes in the first cycle after the edge that samples `vs_en` high.
- R5: `vs_n` goes low on each `frame_start` cycle and stays low for exactly VS_LINES*HS_PERIOD cycles, where VS_LINES is between 1 and 5.
- R6: `line_start` is high only in the cycle in which `hs_n` falls.
- R7: `frame_start` is high only in the cycle in which `vs_n` falls.
- R8: After an edge that samples an enable low, that sync's counter returns to zero. Its sync output stays high and its strobe stays low until the enable is sampled high again. The count then restarts from the beginning of a period.
- R9: If `vs_en` is raised D cycles before `hs_en` (0 < D < HS_PERIOD), every `frame_start` is followed by a `line_start` exactly D cycles later.
- R10: Each sync depends only on its own enable. Turning `hs_en` on or off does not change the timing of `vs_n` or `frame_start`, and turning `vs_en` on or off does not change `hs_n` or `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-port clock, three ticks per pixel |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_en | input | 1 | Runs the line counter while high |
| vs_en | input | 1 | Runs the frame counter while high |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| line_start | output | 1 | One-cycle strobe on each falling edge of hs_n |
| frame_start | output | 1 | One-cycle strobe on each falling edge of vs_n |

## Verification
The hardest case to reach is the fixed phase between the two counters. It appears only when both counters run together, with the frame enable leading by a known number of cycles, for longer than one full frame. The bench therefore overrides the parameters with a short line and a four-line frame. It then raises the two enables with leads of 1 and 7 cycles and measures the gap from a later frame strobe to the next line strobe. Other runs disable the line counter while the frame counter keeps going, and restart it after a single idle cycle, so that the restart and independence rules are also checked against the scoreboard.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int TICKS_PER_PIX = 3,
  parameter int LINE_PIXELS   = 408,
  parameter int HS_WIDTH      = 90,
  parameter int FRAME_LINES   = 241,
  parameter int VS_LINES      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_en,
  input  logic vs_en,
  output logic hs_n,
  output logic vs_n,
  output logic line_start,
  output logic frame_start
);

  localparam int HS_PERIOD = TICKS_PER_PIX * LINE_PIXELS;
  localparam int VS_PERIOD = HS_PERIOD * FRAME_LINES;
  localparam int VS_WIDTH  = HS_PERIOD * VS_LINES;
  localparam int HW = $clog2(HS_PERIOD + 1);
  localparam int VW = $clog2(VS_PERIOD + 1);
  localparam logic [HW-1:0] H_LAST = HW'(HS_PERIOD - 1);
  localparam logic [HW-1:0] H_PW   = HW'(HS_WIDTH);
  localparam logic [VW-1:0] V_LAST = VW'(VS_PERIOD - 1);
  localparam logic [VW-1:0] V_PW   = VW'(VS_WIDTH);

  initial begin
    vs_lines_range_chk: assert (VS_LINES >= 1 && VS_LINES <= 5 && HS_WIDTH >= 1 && HS_WIDTH < HS_PERIOD);
  end

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_on, v_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_on <= 1'b0;
      hcnt <= '0;
    end else if (!hs_en) begin
      h_on <= 1'b0;
      hcnt <= '0;
    end else begin
      h_on <= 1'b1;
      if (h_on) hcnt <= (hcnt == H_LAST) ? '0 : hcnt + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_on <= 1'b0;
      vcnt <= '0;
    end else if (!vs_en) begin
      v_on <= 1'b0;
      vcnt <= '0;
    end else begin
      v_on <= 1'b1;
      if (v_on) vcnt <= (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
    end
  end

  assign hs_n        = ~(h_on && hcnt < H_PW);
  assign vs_n        = ~(v_on && vcnt < V_PW);
  assign line_start  = h_on && hcnt == '0;
  assign frame_start = v_on && vcnt == '0;

  // R6
  line_strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (!hs_n && $past(hs_n)));

  // R3
  hs_fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_n) |-> line_start);

  // R7
  frame_strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!vs_n && $past(vs_n)));

  // R5
  vs_fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_n) |-> frame_start);

  // R8
  hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |=> (hs_n && !line_start));

  // R8
  vs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_en |=> (vs_n && !frame_start));

  // R2
  line_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

endmodule

// File: tb/test_lcd_sync_gen.sv
module test_lcd_sync_gen;
  localparam int TPP = 3, LP = 8, HSW = 5, FL = 4, VSL = 2;
  localparam int HP = TPP * LP, VP = HP * FL, VWD = HP * VSL;

  logic clk = 0, rst_n = 0, hs_en = 0, vs_en = 0;
  logic hs_n, vs_n, line_start, frame_start;
  int cyc = 0, compared = 0, mismatched = 0;
  int exp_line[$], exp_frame[$];
  int h_start = -1, h_end = -1, v_start = -1, v_end = -1;
  bit done = 0;

  lcd_sync_gen #(.TICKS_PER_PIX(TPP), .LINE_PIXELS(LP), .HS_WIDTH(HSW),
                 .FRAME_LINES(FL), .VS_LINES(VSL)) i_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .vs_en(vs_en),
    .hs_n(hs_n), .vs_n(vs_n), .line_start(line_start), .frame_start(frame_start));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic hs_run(input int n);
    int p;
    @(negedge clk);
    hs_en = 1;
    p = cyc + 1;
    h_start = p; h_end = p + n;
    for (int k = p; k < p + n; k += HP) exp_line.push_back(k);
    repeat (n) @(negedge clk);
    hs_en = 0;
  endtask

  task automatic vs_run(input int n);
    int p;
    @(negedge clk);
    vs_en = 1;
    p = cyc + 1;
    v_start = p; v_end = p + n;
    for (int k = p; k < p + n; k += VP) exp_frame.push_back(k);
    repeat (n) @(negedge clk);
    vs_en = 0;
  endtask

  // R9: gap from a frame strobe to the next line strobe
  task automatic check_phase(input int lead);
    int f;
    repeat (lead + 3) @(negedge clk);
    do @(negedge clk); while (!frame_start);
    f = cyc;
    do @(negedge clk); while (!line_start);
    check(cyc - f == lead, "R9 phase", cyc - f, lead);
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n && !done) begin
    bit hl, vl;
    if (exp_line.size() > 0 && exp_line[0] == cyc) begin
      check(line_start, "R2 line_start", line_start, 1);
      void'(exp_line.pop_front());
    end else check(!line_start, "R2/R6 line_start", line_start, 0);
    if (exp_frame.size() > 0 && exp_frame[0] == cyc) begin
      check(frame_start, "R4 frame_start", frame_start, 1);
      void'(exp_frame.pop_front());
    end else check(!frame_start, "R4/R7 frame_start", frame_start, 0);
    hl = (cyc >= h_start && cyc < h_end && h_start >= 0) && ((cyc - h_start) % HP) < HSW;
    vl = (cyc >= v_start && cyc < v_end && v_start >= 0) && ((cyc - v_start) % VP) < VWD;
    check(hs_n == !hl, "R3/R8/R10 hs_n", hs_n, !hl);
    check(vs_n == !vl, "R5/R8/R10 vs_n", vs_n, !vl);
  end

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
    finish_run();
  end

  initial begin
    #1;
    // R1: outputs during reset
    check(hs_n && vs_n && !line_start && !frame_start, "R1 reset",
          {hs_n, vs_n, line_start, frame_start}, 4'b1100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(hs_n && vs_n && !line_start && !frame_start, "R1 after reset",
          {hs_n, vs_n, line_start, frame_start}, 4'b1100);
    repeat (5) @(negedge clk);
    // R9 lead of 1
    fork
      vs_run(400);
      begin repeat (1) @(negedge clk); hs_run(380); end
      check_phase(1);
    join
    repeat (20) @(negedge clk);
    // R9 lead of 7
    fork
      vs_run(300);
      begin repeat (7) @(negedge clk); hs_run(250); end
      check_phase(7);
    join
    repeat (10) @(negedge clk);
    // R10: line counter stopped while the frame counter keeps running
    fork
      vs_run(300);
      begin repeat (10) @(negedge clk); hs_run(50); end
    join
    // R8: restart after a single idle cycle, frame counter off
    hs_run(100);
    hs_run(60);
    repeat (10) @(negedge clk);
    // R10: frame counter toggled while the line counter runs
    fork
      hs_run(260);
      begin repeat (30) @(negedge clk); vs_run(110); end
    join
    repeat (10) @(negedge clk);
    check(exp_line.size() == 0, "R2 pending line strobes", exp_line.size(), 0);
    check(exp_frame.size() == 0, "R4 pending frame strobes", exp_frame.size(), 0);
    finish_run();
  end
endmodule